// File: doc/BRIEF.md
# 16-bit HL Accumulating Adder Slice

This block is the execution slice of an 8-bit processor core that performs the 16-bit register-pair additions whose destination is the HL pair. It is given the instruction byte, a flag saying whether the 0xED prefix came before it, the contents of the B, C, D, E, H and L registers and the stack pointer, the current flag byte and the current internal address latch (WZ). From these it forms the new H and L bytes, the new flag byte and the new WZ value within the same cycle.

Two instruction families are decoded. The plain add forms take the register pair from bits 5:4 of the opcode and add it to HL. They write only the carry, half-carry, N and the two undocumented copy flags. The prefixed add-with-carry forms use the same pair selection and also add the incoming carry. They rewrite the whole flag byte, including sign, zero and signed overflow. As a side effect, WZ is loaded with the old HL plus one. An opcode that belongs to neither family raises an illegal indication and passes every piece of state through unchanged. A registered strobe marks each accepted input one cycle after it was presented.

Top module: `hl_add16_unit`

## Requirements
- R1: Without the prefix, opcodes 0x09, 0x19, 0x29 and 0x39 add BC, DE, HL and SP to HL modulo 2^16; the result's high byte goes to h_out and its low byte to l_out.
- R2: With ed_prefix set, opcodes 0x4A, 0x5A, 0x6A and 0x7A add BC, DE, HL and SP, plus the carry flag (flags_in bit 0), to HL modulo 2^16.
- R3: For every recognised opcode, wz_out equals the HL value before the operation plus one, modulo 2^16.
- R4: The carry flag (flags_out bit 0) is the carry out of bit 15 of the full sum.
- R5: The half-carry flag (flags_out bit 4) is the carry out of bit 11 of the sum.
- R6: Flag bit 5 copies result bit 13 and flag bit 3 copies result bit 11.
- R7: The plain add forms leave flag bits 7 (sign), 6 (zero) and 2 (parity/overflow) equal to flags_in. Both families clear flag bit 1 (N).
- R8: The add-with-carry forms set bit 7 to result bit 15, set bit 6 when the 16-bit result is zero, and set bit 2 on signed two's-complement overflow.
- R9: When in_valid is high and the opcode/prefix pair is not one of the eight above, illegal is 1 and h_out, l_out, flags_out and wz_out equal h_in, l_in, flags_in and wz_in.
- R10: done is 0 in reset and equals in_valid as sampled at the previous rising clock edge.
- R11: The plain add forms ignore the incoming carry flag: the result is the same whether flags_in bit 0 is 0 or 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Inputs carry an instruction this cycle |
| ed_prefix | input | 1 | Opcode was preceded by the 0xED prefix |
| opcode | input | 8 | Instruction byte |
| b_in | input | 8 | Register B |
| c_in | input | 8 | Register C |
| d_in | input | 8 | Register D |
| e_in | input | 8 | Register E |
| h_in | input | 8 | Register H |
| l_in | input | 8 | Register L |
| sp_in | input | 16 | Stack pointer |
| flags_in | input | 8 | Current flag byte (S Z Y H X P/V N C, bit 7 to 0) |
| wz_in | input | 16 | Current internal address latch |
| h_out | output | 8 | New H |
| l_out | output | 8 | New L |
| flags_out | output | 8 | New flag byte |
| wz_out | output | 16 | New internal address latch |
| illegal | output | 1 | Valid input with an unrecognised opcode |
| done | output | 1 | Registered strobe one cycle after in_valid |

## Verification
The clocked assertions assume that the datapath inputs are steady from the moment in_valid rises until the following rising edge. Their consequents compare combinational outputs against the inputs at that edge. The bench drives every input on the falling edge and holds it for a full cycle, so each edge sees a settled operand set. The overflow and carry checks treat the register values as unconstrained. The stimulus therefore deliberately covers the sign-boundary operands 0x7FFF, 0x8000 and 0xFFFF, with the carry flag both set and clear.

// File: rtl/hl_add_pkg.sv
package hl_add_pkg;

  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;
  localparam int SUM_W  = WORD_W + 1;

  // flag byte layout, bit 7 down to bit 0
  localparam int FLAG_S  = 7;
  localparam int FLAG_Z  = 6;
  localparam int FLAG_Y  = 5;
  localparam int FLAG_H  = 4;
  localparam int FLAG_X  = 3;
  localparam int FLAG_PV = 2;
  localparam int FLAG_N  = 1;
  localparam int FLAG_C  = 0;

  // byte-wide flag positions shifted up by the extra width of a word op
  localparam int SHIFT_UP = WORD_W - BYTE_W;
  localparam int HC_BIT   = FLAG_H + SHIFT_UP;   // bit 12 of a^b^res
  localparam int Y_BIT    = FLAG_Y + SHIFT_UP;   // result bit 13
  localparam int X_BIT    = FLAG_X + SHIFT_UP;   // result bit 11
  localparam int SIGN_BIT = WORD_W - 1;

  typedef enum logic [1:0] {
    PAIR_BC = 2'd0,
    PAIR_DE = 2'd1,
    PAIR_HL = 2'd2,
    PAIR_SP = 2'd3
  } pair_e;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [BYTE_W-1:0] byte_t;

  function automatic word_t join_pair(input byte_t hi, input byte_t lo);
    return {hi, lo};
  endfunction

  function automatic logic [SUM_W-1:0] wide_sum(input word_t a, input word_t b,
                                                input logic cin);
    return {1'b0, a} + {1'b0, b} + {{(SUM_W-1){1'b0}}, cin};
  endfunction

  function automatic logic half_of(input word_t a, input word_t b, input word_t r);
    word_t t;
    t = a ^ b ^ r;
    return t[HC_BIT];
  endfunction

  function automatic logic ovf_of(input word_t a, input word_t b, input word_t r);
    return ~(a[SIGN_BIT] ^ b[SIGN_BIT]) & (a[SIGN_BIT] ^ r[SIGN_BIT]);
  endfunction

endpackage

// File: rtl/hl_add_decode.sv
module hl_add_decode
  import hl_add_pkg::*;
(
  input  logic       in_valid,
  input  logic       ed_prefix,
  input  logic [7:0] opcode,
  output logic       add_hit,
  output logic       adc_hit,
  output logic       bad_op,
  output pair_e      pair_sel
);

  logic plain_shape;
  logic pfx_shape;

  // plain form: 00pp1001, prefixed form: 01pp1010
  always_comb begin
    plain_shape = (opcode[7:6] == 2'b00) && (opcode[3:0] == 4'b1001);
    pfx_shape   = (opcode[7:6] == 2'b01) && (opcode[3:0] == 4'b1010);
    add_hit     = in_valid && !ed_prefix && plain_shape;
    adc_hit     = in_valid &&  ed_prefix && pfx_shape;
    bad_op      = in_valid && !add_hit && !adc_hit;
    pair_sel    = pair_e'(opcode[5:4]);
  end

endmodule

// File: rtl/hl_add_operand_mux.sv
module hl_add_operand_mux
  import hl_add_pkg::*;
(
  input  pair_e pair_sel,
  input  byte_t b_in,
  input  byte_t c_in,
  input  byte_t d_in,
  input  byte_t e_in,
  input  word_t hl_word,
  input  word_t sp_in,
  output word_t rr_word
);

  localparam int NUM_PAIRS = 4;

  word_t cand [NUM_PAIRS];

  genvar gi;
  generate
    for (gi = 0; gi < NUM_PAIRS; gi++) begin : g_pair
      if (gi == int'(PAIR_BC)) begin : g_bc
        assign cand[gi] = join_pair(b_in, c_in);
      end else if (gi == int'(PAIR_DE)) begin : g_de
        assign cand[gi] = join_pair(d_in, e_in);
      end else if (gi == int'(PAIR_HL)) begin : g_hl
        assign cand[gi] = hl_word;
      end else begin : g_sp
        assign cand[gi] = sp_in;
      end
    end
  endgenerate

  assign rr_word = cand[pair_sel];

endmodule

// File: rtl/hl_add_alu.sv
module hl_add_alu
  import hl_add_pkg::*;
(
  input  word_t hl_word,
  input  word_t rr_word,
  input  logic  with_carry,
  input  byte_t flags_in,
  output word_t res_word,
  output word_t wz_next,
  output byte_t flags_new,
  output logic  carry_out,
  output logic  half_out,
  output logic  ovf_out
);

  logic [SUM_W-1:0] sum;
  logic             cin;

  always_comb begin
    cin       = with_carry & flags_in[FLAG_C];
    sum       = wide_sum(hl_word, rr_word, cin);
    res_word  = sum[WORD_W-1:0];
    carry_out = sum[WORD_W];
    half_out  = half_of(hl_word, rr_word, res_word);
    ovf_out   = ovf_of(hl_word, rr_word, res_word);
    wz_next   = hl_word + word_t'(1);

    flags_new          = flags_in;   // plain form keeps S, Z, P/V
    flags_new[FLAG_Y]  = res_word[Y_BIT];
    flags_new[FLAG_H]  = half_out;
    flags_new[FLAG_X]  = res_word[X_BIT];
    flags_new[FLAG_N]  = 1'b0;
    flags_new[FLAG_C]  = carry_out;
    if (with_carry) begin
      flags_new[FLAG_S]  = res_word[SIGN_BIT];
      flags_new[FLAG_Z]  = (res_word == '0);
      flags_new[FLAG_PV] = ovf_out;
    end
  end

endmodule

// File: rtl/hl_add16_unit.sv
module hl_add16_unit
  import hl_add_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic        ed_prefix,
  input  logic [7:0]  opcode,
  input  logic [7:0]  b_in,
  input  logic [7:0]  c_in,
  input  logic [7:0]  d_in,
  input  logic [7:0]  e_in,
  input  logic [7:0]  h_in,
  input  logic [7:0]  l_in,
  input  logic [15:0] sp_in,
  input  logic [7:0]  flags_in,
  input  logic [15:0] wz_in,
  output logic [7:0]  h_out,
  output logic [7:0]  l_out,
  output logic [7:0]  flags_out,
  output logic [15:0] wz_out,
  output logic        illegal,
  output logic        done
);

  logic  add_hit, adc_hit, bad_op;
  pair_e pair_sel;
  word_t hl_word, rr_word, res_word, wz_next;
  byte_t flags_new;
  logic  carry_out, half_out, ovf_out;
  logic  legal;
  logic  done_q;

  assign hl_word = join_pair(h_in, l_in);
  assign legal   = add_hit | adc_hit;

  hl_add_decode u_dec (
    .in_valid (in_valid),
    .ed_prefix(ed_prefix),
    .opcode   (opcode),
    .add_hit  (add_hit),
    .adc_hit  (adc_hit),
    .bad_op   (bad_op),
    .pair_sel (pair_sel)
  );

  hl_add_operand_mux u_mux (
    .pair_sel(pair_sel),
    .b_in    (b_in),
    .c_in    (c_in),
    .d_in    (d_in),
    .e_in    (e_in),
    .hl_word (hl_word),
    .sp_in   (sp_in),
    .rr_word (rr_word)
  );

  hl_add_alu u_alu (
    .hl_word   (hl_word),
    .rr_word   (rr_word),
    .with_carry(adc_hit),
    .flags_in  (flags_in),
    .res_word  (res_word),
    .wz_next   (wz_next),
    .flags_new (flags_new),
    .carry_out (carry_out),
    .half_out  (half_out),
    .ovf_out   (ovf_out)
  );

  always_comb begin
    if (legal) begin
      h_out     = res_word[WORD_W-1:BYTE_W];
      l_out     = res_word[BYTE_W-1:0];
      flags_out = flags_new;
      wz_out    = wz_next;
    end else begin
      h_out     = h_in;
      l_out     = l_in;
      flags_out = flags_in;
      wz_out    = wz_in;
    end
    illegal = bad_op;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= in_valid;
  end
  assign done = done_q;

  // decode produces exactly one verdict for a valid input (R1, R2, R9)
  p_one_verdict_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ($countones({add_hit, adc_hit, bad_op}) == 1));

  p_wz_plus_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
    legal |-> (wz_out == hl_word + 16'd1));

  p_add_carry_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    add_hit |-> (flags_out[FLAG_C] == ({h_out, l_out} < hl_word)));

  p_add_keeps_szp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    add_hit |-> (flags_out[FLAG_S] == flags_in[FLAG_S] &&
                 flags_out[FLAG_Z] == flags_in[FLAG_Z] &&
                 flags_out[FLAG_PV] == flags_in[FLAG_PV]));

  p_n_cleared_r7: assert property (@(posedge clk) disable iff (!rst_n)
    legal |-> !flags_out[FLAG_N]);

  p_adc_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    adc_hit |-> (flags_out[FLAG_Z] == ({h_out, l_out} == 16'h0000)));

  p_illegal_passthru_r9: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (h_out == h_in && l_out == l_in &&
                 flags_out == flags_in && wz_out == wz_in));

  p_strobe_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> done);

  p_strobe_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !done);

endmodule

// File: tb/hl_add16_unit_tb_top.sv
module hl_add16_unit_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;
  localparam int NVEC       = 16;
  localparam logic [15:0] WZ_SEED = 16'hA5A5;

  // {ed, opcode, hl, bc, de, sp, flags}
  localparam logic [80:0] VEC [NVEC] = '{
    {1'b0, 8'h09, 16'h1234, 16'h1111, 16'h0000, 16'h0000, 8'h00},
    {1'b0, 8'h19, 16'h0FFF, 16'h0000, 16'h0001, 16'h0000, 8'h00},
    {1'b0, 8'h29, 16'h8000, 16'h0000, 16'h0000, 16'h0000, 8'h00},
    {1'b0, 8'h39, 16'hFFFF, 16'h0000, 16'h0000, 16'h0001, 8'hFE},
    {1'b0, 8'h19, 16'h2000, 16'h0000, 16'h0800, 16'h0000, 8'h00},
    {1'b0, 8'h09, 16'h7FFF, 16'h0001, 16'h0000, 16'h0000, 8'h01},
    {1'b1, 8'h4A, 16'h7FFF, 16'h0000, 16'h0000, 16'h0000, 8'h01},
    {1'b1, 8'h5A, 16'hFFFF, 16'h0000, 16'h0000, 16'h0000, 8'h01},
    {1'b1, 8'h6A, 16'h4000, 16'h0000, 16'h0000, 16'h0000, 8'h00},
    {1'b1, 8'h7A, 16'h8000, 16'h0000, 16'h0000, 16'h8000, 8'hC4},
    {1'b1, 8'h4A, 16'h0FFF, 16'h0000, 16'h0000, 16'h0000, 8'h01},
    {1'b1, 8'h5A, 16'h1234, 16'h0000, 16'h4321, 16'h0000, 8'h00},
    {1'b0, 8'h4A, 16'h1234, 16'h5555, 16'h0000, 16'h0000, 8'h5A},
    {1'b1, 8'h09, 16'h1234, 16'h5555, 16'h0000, 16'h0000, 8'hA5},
    {1'b0, 8'h00, 16'hBEEF, 16'h0001, 16'h0000, 16'h0000, 8'h3C},
    {1'b1, 8'h4B, 16'h00FF, 16'h0001, 16'h0000, 16'h0000, 8'hC3}
  };

  logic        clk = 1'b0;
  logic        rst_n, in_valid, ed_prefix;
  logic [7:0]  opcode, b_in, c_in, d_in, e_in, h_in, l_in, flags_in;
  logic [15:0] sp_in, wz_in, wz_out;
  logic [7:0]  h_out, l_out, flags_out;
  logic        illegal, done;

  int checks = 0;
  int errors = 0;
  logic finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hl_add16_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .ed_prefix(ed_prefix),
    .opcode(opcode), .b_in(b_in), .c_in(c_in), .d_in(d_in), .e_in(e_in),
    .h_in(h_in), .l_in(l_in), .sp_in(sp_in), .flags_in(flags_in),
    .wz_in(wz_in), .h_out(h_out), .l_out(l_out), .flags_out(flags_out),
    .wz_out(wz_out), .illegal(illegal), .done(done)
  );

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // reference model built from the requirements with integer arithmetic
  task automatic model(input logic ed, input logic [7:0] op, input int hl,
                       input int bc, input int de, input int sp,
                       input logic [7:0] fin, output logic legal,
                       output int res, output logic [7:0] fexp, output int wz);
    int rr, ci, full, shl, srr, ssum;
    logic is_adc;
    legal  = 1'b0;
    is_adc = 1'b0;
    rr     = 0;
    if (!ed && op inside {8'h09, 8'h19, 8'h29, 8'h39}) legal = 1'b1;
    if (ed && op inside {8'h4A, 8'h5A, 8'h6A, 8'h7A}) begin
      legal  = 1'b1;
      is_adc = 1'b1;
    end
    case (op[5:4])
      2'd0: rr = bc;
      2'd1: rr = de;
      2'd2: rr = hl;
      default: rr = sp;
    endcase
    ci   = is_adc ? int'(fin[0]) : 0;
    full = hl + rr + ci;
    res  = full % 65536;
    wz   = (hl + 1) % 65536;
    fexp = fin;
    fexp[0] = (full >= 65536);
    fexp[4] = ((hl % 4096) + (rr % 4096) + ci) >= 4096;
    fexp[5] = ((res / 8192) % 2) == 1;
    fexp[3] = ((res / 2048) % 2) == 1;
    fexp[1] = 1'b0;
    if (is_adc) begin
      shl  = (hl >= 32768) ? hl - 65536 : hl;
      srr  = (rr >= 32768) ? rr - 65536 : rr;
      ssum = shl + srr + ci;
      fexp[7] = (res >= 32768);
      fexp[6] = (res == 0);
      fexp[2] = (ssum > 32767) || (ssum < -32768);
    end
  endtask

  task automatic drive(input logic [80:0] v);
    ed_prefix = v[80];
    opcode    = v[79:72];
    {h_in, l_in} = v[71:56];
    {b_in, c_in} = v[55:40];
    {d_in, e_in} = v[39:24];
    sp_in     = v[23:8];
    flags_in  = v[7:0];
    wz_in     = WZ_SEED;
    in_valid  = 1'b1;
  endtask

  task automatic check_vec(input logic [80:0] v);
    logic legal;
    int res, wz;
    logic [7:0] fexp;
    string rq;
    model(v[80], v[79:72], int'(v[71:56]), int'(v[55:40]), int'(v[39:24]),
          int'(v[23:8]), v[7:0], legal, res, fexp, wz);
    if (legal) begin
      rq = v[80] ? "R2" : "R1";
      check({h_out, l_out} == 16'(res), rq, {h_out, l_out}, res);
      check(flags_out[0] == fexp[0], "R4 carry", flags_out, fexp);
      check(flags_out[4] == fexp[4], "R5 half", flags_out, fexp);
      check({flags_out[5], flags_out[3]} == {fexp[5], fexp[3]}, "R6 yx",
            flags_out, fexp);
      check({flags_out[7:6], flags_out[2:1]} == {fexp[7:6], fexp[2:1]},
            v[80] ? "R8 szv" : "R7 szpn", flags_out, fexp);
      check(wz_out == 16'(wz), "R3 wz", wz_out, wz);
      check(!illegal, "R9 legal", illegal, 0);
    end else begin
      check(illegal, "R9 flag", illegal, 1);
      check({h_out, l_out, flags_out, wz_out} == {v[71:56], v[7:0], WZ_SEED},
            "R9 passthru", {h_out, l_out, flags_out}, {v[71:56], v[7:0]});
    end
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [15:0] keep_hl;
    logic [7:0]  keep_f;
    rst_n = 1'b0;
    drive(VEC[0]);
    in_valid = 1'b1;
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R10 reset", done, 0);
    rst_n = 1'b1;
    in_valid = 1'b0;
    @(negedge clk);
    check(done == 1'b0, "R10 idle", done, 0);

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      drive(VEC[i]);
      #1;
      check_vec(VEC[i]);
    end
    @(negedge clk);
    check(done == 1'b1, "R10 strobe", done, 1);
    in_valid = 1'b0;
    @(negedge clk);
    check(done == 1'b0, "R10 drop", done, 0);

    // R11: plain add ignores the carry flag
    drive({1'b0, 8'h09, 16'h1000, 16'h0234, 16'h0000, 16'h0000, 8'h00});
    #1;
    keep_hl = {h_out, l_out};
    keep_f  = flags_out;
    flags_in = 8'h01;
    #1;
    check({h_out, l_out} == keep_hl && keep_hl == 16'h1234, "R11 result",
          {h_out, l_out}, keep_hl);
    check(flags_out[4:3] == keep_f[4:3], "R11 flags", flags_out, keep_f);

    // R2 versus R11: the prefixed form does use it
    drive({1'b1, 8'h4A, 16'h1000, 16'h0234, 16'h0000, 16'h0000, 8'h01});
    #1;
    check({h_out, l_out} == 16'h1235, "R2 carry in", {h_out, l_out}, 16'h1235);

    // R3 wrap of WZ at HL = FFFF
    drive({1'b0, 8'h29, 16'hFFFF, 16'h0000, 16'h0000, 16'h0000, 8'h00});
    #1;
    check(wz_out == 16'h0000, "R3 wrap", wz_out, 0);
    check({h_out, l_out} == 16'hFFFE && flags_out[0], "R4 hl+hl",
          {h_out, l_out}, 16'hFFFE);

    // R9: invalid input does not raise illegal
    drive({1'b0, 8'h00, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 8'h00});
    in_valid = 1'b0;
    #1;
    check(!illegal, "R9 gated", illegal, 0);
    @(negedge clk);
    check(done == 1'b0, "R10 no strobe", done, 0);

    @(negedge clk);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule